// File: doc/BRIEF.md
# SPI Real-Time Clock Register Slave

This block is the register side of a real-time clock reached over SPI. It holds sixteen 8-bit registers. Software keeps BCD time and date values there, along with alarm settings and two control bytes. The block does no timekeeping of its own. It stores what the master writes and returns it on read. Two control bits are brought out as pins. One shows that 24-hour format is selected. The other is a sticky flag showing that the oscillator has stopped since power-on.

Every chip-select window opens with a command byte. The upper nibble of that byte names a register. Bits 3:2 choose one of four modes: burst write, burst read, single write or single read. After the command byte, each byte either writes the current register or returns its contents. In a burst the register address advances after each data byte. In single mode it stays on the command's register. SPI inputs pass through a synchronizer into the system clock domain, so SCLK has to run several times slower than `clk`.

The control state machine has five states. ST_IDLE means chip select is low. ST_CMD is receiving the command byte. ST_WR is receiving write data. ST_RD is sending read data. ST_SKIP discards the bytes that follow a single write. The transitions are:
- ST_IDLE→ST_CMD when chip select rises.
- ST_CMD→ST_RD or ST_CMD→ST_WR at the end of the command byte, chosen by bit 2.
- ST_WR→ST_SKIP after the data byte of a single write.
- ST_WR→ST_WR after each burst byte.
- Any state→ST_IDLE whenever chip select is low.

Top module: `spi_rtc_regs`

## Requirements
- R1: A transaction's first byte is a command: bits 7:4 give the register address, bit 3 set means single mode (clear means burst), and bit 2 set means read (clear means write). Bits 1:0 are ignored. So 0x0 is burst write, 0x4 burst read, 0x8 single write and 0xC single read.
- R2: Chip select is active high and SCLK idles low. The slave samples MOSI on the falling SCLK edge and changes MISO on the rising edge. Bytes travel most significant bit first.
- R3: After a read command, each following byte period returns the addressed register on MISO while the master shifts dummy data in.
- R4: In burst mode the address advances by one after every data byte and wraps from 15 to 0, for both reads and writes.
- R5: A single write stores only the first data byte after the command. Later bytes in the same transaction change nothing.
- R6: A single read returns the same register in every data byte of the transaction.
- R7: After reset every register reads 0x00, except register 15 (control 2), which reads 0x10. The `osc_stop` pin mirrors bit 4 of register 15.
- R8: A write cannot set bit 4 of register 15. A written byte with bit 4 equal to 0 clears it, and a written 1 leaves it unchanged. The other bits of register 15 take the written value.
- R9: The `fmt_24h` pin mirrors bit 5 of register 14 (control 1), which takes the written value.
- R10: Register 13 is unimplemented. It always reads 0x00 and writes to it are discarded.
- R11: Dropping chip select mid-byte discards the partial byte without writing anything. The next transaction again starts with a command byte.
- R12: MISO is 0 whenever the slave is not sending read data: while chip select is low, during the command byte and during write bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI inputs are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs | input | 1 | Chip select, active high |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| fmt_24h | output | 1 | 24-hour format select (register 14 bit 5) |
| osc_stop | output | 1 | Oscillator-stopped flag (register 15 bit 4) |

## Verification
The in-RTL assertions check the cycle-level rules on every cycle:
- chip-select abort returns the machine to idle with a cleared bit count,
- MISO stays low outside the read state,
- the burst address steps by one and the single-mode address holds,
- a single write is followed by the skip state,
- the stop flag never rises after reset and clears on a write of 0,
- the format pin follows the written bit.

Only the bench's scenarios can show that the right bytes come back:
- data ordering on the wire,
- wrap-around from register 15 to 0,
- the unimplemented register reading zero,
- partial bytes leaving the register file untouched.

It compares each read byte with a reference register model. Directed cases run first, followed by seeded random transactions.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_SKIP
    } spi_state_t;

    // Command byte bit positions (R1)
    localparam int unsigned CMD_READ_BIT   = 2;
    localparam int unsigned CMD_SINGLE_BIT = 3;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic mosi_i,
    output logic cs_o,
    output logic mosi_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] mosi_p;
    logic              sclk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_p      <= '0;
            sclk_p    <= '0;
            mosi_p    <= '0;
            sclk_last <= 1'b0;
        end else begin
            cs_p      <= {cs_p[STAGES-2:0], cs_i};
            sclk_p    <= {sclk_p[STAGES-2:0], sclk_i};
            mosi_p    <= {mosi_p[STAGES-2:0], mosi_i};
            sclk_last <= sclk_p[STAGES-1];
        end
    end

    assign cs_o   = cs_p[STAGES-1];
    assign mosi_o = mosi_p[STAGES-1];
    assign rise_o = sclk_p[STAGES-1] & ~sclk_last;
    assign fall_o = ~sclk_p[STAGES-1] & sclk_last;

    // R2: a detected edge is a single-cycle pulse
    assert_edge_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o || fall_o) |=> !(rise_o || fall_o));
endmodule

// File: rtl/rtc_reg_file.sv
module rtc_reg_file #(
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int CTL1_ADDR = 14,
    parameter int CTL2_ADDR = 15,
    parameter int HOLE_ADDR = 13,
    parameter int FMT_BIT   = 5,
    parameter int OSC_BIT   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          fmt_24h,
    output logic          osc_stop
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs_w [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        if (g == HOLE_ADDR) begin : g_hole
            // R10: unimplemented location
            assign regs_w[g] = '0;
        end else if (g == CTL2_ADDR) begin : g_ctl2
            logic [DW-1:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= DW'(1) << OSC_BIT;
                end else if (wr_en && wr_addr == AW'(g)) begin
                    for (int b = 0; b < DW; b++) begin
                        if (b == OSC_BIT) cell_q[b] <= cell_q[b] & wr_data[b];
                        else              cell_q[b] <= wr_data[b];
                    end
                end
            end
            assign regs_w[g] = cell_q;
        end else begin : g_plain
            logic [DW-1:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             cell_q <= '0;
                else if (wr_en && wr_addr == AW'(g))    cell_q <= wr_data;
            end
            assign regs_w[g] = cell_q;
        end
    end

    assign rd_data  = regs_w[rd_addr];
    assign fmt_24h  = regs_w[CTL1_ADDR][FMT_BIT];
    assign osc_stop = regs_w[CTL2_ADDR][OSC_BIT];

    // R8: the stop flag can never be set after reset
    assert_osc_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(osc_stop));

    // R8: writing 0 into the flag bit clears it
    assert_osc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(CTL2_ADDR) && !wr_data[OSC_BIT]) |=> !osc_stop);

    // R9: format pin follows the written control bit
    assert_fmt_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(CTL1_ADDR)) |=> (fmt_24h == $past(wr_data[FMT_BIT])));
endmodule

// File: rtl/rtc_spi_fsm.sv
module rtc_spi_fsm
    import rtc_spi_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          mosi_s,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          miso
);
    localparam int CW = $clog2(DW);

    spi_state_t    state_q, state_d;
    logic [CW-1:0] bit_cnt_q;
    logic [DW-1:0] rx_q, rx_next, tx_q;
    logic [AW-1:0] addr_q, addr_d;
    logic          burst_q;
    logic          miso_q;
    logic          byte_done;

    assign rx_next   = {rx_q[DW-2:0], mosi_s};
    assign byte_done = cs_s && sclk_fall && (bit_cnt_q == CW'(DW-1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!cs_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;
                ST_CMD:  if (byte_done) state_d = rx_next[CMD_READ_BIT] ? ST_RD : ST_WR;
                ST_WR:   if (byte_done && !burst_q) state_d = ST_SKIP;
                ST_RD:   state_d = ST_RD;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Address selection: command load, burst step, or hold
    always_comb begin
        addr_d = addr_q;
        if (byte_done) begin
            if (state_q == ST_CMD)
                addr_d = rx_next[DW-1 -: AW];
            else if ((state_q == ST_WR || state_q == ST_RD) && burst_q)
                addr_d = addr_q + 1'b1;
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            addr_q    <= '0;
            burst_q   <= 1'b0;
            miso_q    <= 1'b0;
        end else begin
            addr_q <= addr_d;
            if (!cs_s) begin
                bit_cnt_q <= '0;
                rx_q      <= '0;
            end else if (sclk_fall) begin
                rx_q      <= rx_next;
                bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
            end
            if (byte_done && state_q == ST_CMD)
                burst_q <= ~rx_next[CMD_SINGLE_BIT];
            if (byte_done && state_d == ST_RD)
                tx_q <= rd_data;
            else if (state_q == ST_RD && sclk_rise)
                tx_q <= {tx_q[DW-2:0], 1'b0};
            if (state_d != ST_RD)
                miso_q <= 1'b0;
            else if (state_q == ST_RD && sclk_rise)
                miso_q <= tx_q[DW-1];
        end
    end

    assign rd_addr = addr_d;
    assign wr_en   = byte_done && (state_q == ST_WR);
    assign wr_addr = addr_q;
    assign wr_data = rx_next;
    assign miso    = miso_q;

    // R1: chip select rising always leads into command reception
    assert_cmd_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> (state_q == ST_CMD));

    // R11: chip select low aborts the transfer
    assert_cs_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (state_q == ST_IDLE && bit_cnt_q == '0));

    // R12: MISO quiet outside read state
    assert_miso_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RD) |-> !miso);

    // R4: burst address steps by one, wrapping
    assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && burst_q && (state_q == ST_WR || state_q == ST_RD))
        |=> (addr_q == AW'($past(addr_q) + 1'b1)));

    // R6: single-mode address never moves after the command
    assert_single_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_q && (state_q == ST_WR || state_q == ST_RD || state_q == ST_SKIP))
        |=> $stable(addr_q));

    // R5: single write is followed by discarding
    assert_single_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !burst_q) |=> (state_q == ST_SKIP));
endmodule

// File: rtl/spi_rtc_regs.sv
module spi_rtc_regs #(
    parameter int DW          = 8,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs,
    input  logic spi_sclk,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic fmt_24h,
    output logic osc_stop
);
    logic          cs_s, mosi_s, sclk_rise, sclk_fall;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_data;

    rtc_spi_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_i   (spi_cs),
        .sclk_i (spi_sclk),
        .mosi_i (spi_mosi),
        .cs_o   (cs_s),
        .mosi_o (mosi_s),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    rtc_spi_fsm #(.DW(DW), .AW(AW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso      (spi_miso)
    );

    rtc_reg_file #(.DW(DW), .AW(AW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .fmt_24h  (fmt_24h),
        .osc_stop (osc_stop)
    );
endmodule

// File: tb/test_spi_rtc_regs.sv
`timescale 1ns/1ps
module test_spi_rtc_regs;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs = 1'b0, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, fmt_24h, osc_stop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] m [16];

    always #2.5 clk = ~clk;

    spi_rtc_regs i_spi_rtc_regs (
        .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .fmt_24h(fmt_24h), .osc_stop(osc_stop)
    );

    // Reference write rule: R8 for reg 15, R10 for reg 13
    function automatic logic [7:0] mw(input logic [3:0] a, input logic [7:0] old, input logic [7:0] d);
        if (a == 4'd13) return 8'h00;
        if (a == 4'd15) return {d[7:5], d[4] & old[4], d[3:0]};
        return d;
    endfunction

    task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cs_on();
        @(negedge clk); spi_cs = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk); spi_sclk = 1'b0;
        repeat (4) @(negedge clk);
        spi_cs = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Master: shift on rising, sample on falling, MSB first (R2)
    task automatic send_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            @(negedge clk); spi_sclk = 1'b1; spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic run_txn(input logic single, input logic rd, input logic [3:0] a,
                           input int n, input bit fixed, input logic [7:0] fv);
        logic [7:0] rx, d;
        logic [3:0] cur;
        cs_on();
        send_bits({a, single, rd, 2'($urandom)}, 8, rx);   // R1 low bits random
        check_eq("R12 miso quiet in command byte", rx, 8'h00);
        cur = a;
        for (int k = 0; k < n; k++) begin
            if (!rd) begin
                d = fixed ? fv : 8'($urandom);
                send_bits(d, 8, rx);
                check_eq("R12 miso quiet in write byte", rx, 8'h00);
                if (!single || k == 0) m[cur] = mw(cur, m[cur], d);   // R5
                if (!single) cur = cur + 4'd1;                          // R4
            end else begin
                send_bits(8'($urandom), 8, rx);
                if (single) check_eq("R6 single read repeat (R2/R3)", rx, m[cur]);
                else        check_eq("R4 burst read data (R2/R3)", rx, m[cur]);
                if (!single) cur = cur + 4'd1;
            end
        end
        cs_off();
        check_eq("R12 miso low with cs low", 8'(spi_miso), 8'h00);
        check_eq("R9 fmt_24h pin", 8'(fmt_24h), 8'(m[14][5]));
        check_eq("R7/R8 osc_stop pin", 8'(osc_stop), 8'(m[15][4]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) m[i] = 8'h00;
        m[15] = 8'h10;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7 reset state
        check_eq("R7 reset osc_stop", 8'(osc_stop), 8'h01);
        check_eq("R7 reset fmt_24h", 8'(fmt_24h), 8'h00);
        check_eq("R12 reset miso", 8'(spi_miso), 8'h00);
        run_txn(1, 1, 4'd15, 1, 0, 8'h00);       // R7 reads 0x10
        run_txn(1, 1, 4'd3, 2, 0, 8'h00);        // R7 zero register

        // R8 flag cannot be set, zero clears it
        run_txn(1, 0, 4'd15, 1, 1, 8'hFF);
        check_eq("R8 write 1 keeps flag", 8'(osc_stop), 8'h01);
        run_txn(1, 0, 4'd15, 1, 1, 8'hEF);
        check_eq("R8 write 0 clears flag", 8'(osc_stop), 8'h00);
        run_txn(1, 1, 4'd15, 1, 0, 8'h00);
        run_txn(1, 0, 4'd15, 1, 1, 8'hFF);
        check_eq("R8 flag stays clear", 8'(osc_stop), 8'h00);

        // R9 format bit
        run_txn(1, 0, 4'd14, 1, 1, 8'h20);
        check_eq("R9 fmt set", 8'(fmt_24h), 8'h01);
        run_txn(1, 0, 4'd14, 1, 1, 8'hDF);
        check_eq("R9 fmt clear", 8'(fmt_24h), 8'h00);

        // R4 burst from register 0, and wrap 15 -> 0
        run_txn(0, 0, 4'd0, 7, 0, 8'h00);
        run_txn(0, 1, 4'd0, 7, 0, 8'h00);
        run_txn(0, 0, 4'd14, 4, 0, 8'h00);
        run_txn(0, 1, 4'd13, 5, 0, 8'h00);

        // R5 / R6 single mode
        run_txn(1, 0, 4'd2, 3, 0, 8'h00);
        run_txn(1, 1, 4'd2, 3, 0, 8'h00);
        run_txn(1, 1, 4'd3, 1, 0, 8'h00);

        // R10 unimplemented register
        run_txn(1, 0, 4'd13, 1, 1, 8'hA5);
        run_txn(1, 1, 4'd13, 2, 0, 8'h00);

        // R11 abort inside a write data byte
        run_txn(1, 0, 4'd5, 1, 1, 8'h3C);
        cs_on();
        send_bits({4'd5, 4'b1000}, 8, rx);
        send_bits(8'hFF, 4, rx);
        cs_off();
        check_eq("R11 miso after abort", 8'(spi_miso), 8'h00);
        run_txn(1, 1, 4'd5, 1, 0, 8'h00);
        // R11 abort inside a command byte, then a clean read
        cs_on();
        send_bits(8'hFF, 5, rx);
        cs_off();
        run_txn(1, 1, 4'd6, 1, 0, 8'h00);

        // Seeded random traffic
        for (int t = 0; t < 60; t++) begin
            run_txn(1'($urandom), 1'($urandom), 4'($urandom), 1 + int'($urandom % 4), 0, 8'h00);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule